// File: doc/BRIEF.md
# DMA interrupt and status register slice

This block is the interrupt and status portion of a multi-channel DMA controller's register file. For each channel it keeps two raw event flags: one for terminal count (a transfer finished) and one for error. Each is set by a one-cycle pulse from the channel engine and cleared by software writing ones. Masking does not use separate mask registers. The terminal-count and error interrupt enables come from each channel's configuration word, and those enable bits arrive here as input vectors. Software can read both the raw and the masked views. The single interrupt line is the OR of every masked flag.

The slice also provides four more things. An enabled-channels readback mirrors each channel's configuration enable bit. A global configuration register carries the controller enable at bit 0. A sync register holds whatever is written to it. A read-only identification window returns one ID byte per word. Accesses use a plain 32-bit request/write-enable bus with byte addresses. Read data is registered and appears the cycle after the read request. Address bits [1:0] are ignored.

Top module: `dma_irq_regs`

## Requirements
- R1: A read of byte address 0x00 returns (raw terminal-count AND terminal-count enables) OR (raw error AND error enables), one bit per channel at bit position = channel index.
- R2: Byte address 0x04 reads masked terminal-count and 0x0C reads masked error. 0x14 reads raw terminal-count and 0x18 reads raw error. Bits above the channel count read zero.
- R3: A write to 0x08 clears each raw terminal-count flag whose bit is one in the write data. A write to 0x10 does the same for raw error flags. Zero bits leave flags unchanged.
- R4: When a set pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R5: A set pulse on a channel makes its raw flag one on the next cycle, whatever that channel's enable bits are.
- R6: Byte address 0x1C reads one bit per channel, equal to that channel's configuration enable input.
- R7: Byte address 0x30 is the global configuration register and 0x34 is the sync register. Both are 32 bits wide, read back the last value written and reset to zero. Output ctrl_en_o equals configuration bit 0.
- R8: Byte addresses 0xFE0 to 0xFFC read ID bytes in data bits [7:0], with word k returning byte k of the sequence 0x80 (or 0x81 when NUM_CH is not 8), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R9: irq_o is high exactly when some masked terminal-count or masked error bit is set. It follows flag and enable changes combinationally, with no added register.
- R10: Byte addresses 0x20 to 0x2C (soft request) and every other address not listed read zero, and writes to them change no state.
- R11: rdata_o loads the addressed value on the clock edge that samples a read request (req_i high, we_i low) and otherwise holds. After reset it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| tc_set_i | input | NUM_CH | Per-channel terminal-count set pulses |
| err_set_i | input | NUM_CH | Per-channel error set pulses |
| tc_ie_i | input | NUM_CH | Per-channel terminal-count interrupt enable |
| err_ie_i | input | NUM_CH | Per-channel error interrupt enable |
| ch_en_i | input | NUM_CH | Per-channel configuration enable |
| ctrl_en_o | output | 1 | Controller enable (global configuration bit 0) |
| irq_o | output | 1 | Combined interrupt |

## Verification
A corrupted raw flag shows up on irq_o in the same cycle, provided its enable is set. The raw status reads expose it one cycle after a read request, whether or not it is masked. A stuck clear or a lost set pulse, including the case where a set and a clear collide, therefore shows on the first raw read or on the interrupt line. A decode fault that makes a soft-request or unmapped write disturb state is caught by reading back the flags, the configuration and the sync register immediately afterwards.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;

  typedef enum logic [3:0] {
    W_STAT     = 4'd0,
    W_TC_STAT  = 4'd1,
    W_TC_CLR   = 4'd2,
    W_ERR_STAT = 4'd3,
    W_ERR_CLR  = 4'd4,
    W_TC_RAW   = 4'd5,
    W_ERR_RAW  = 4'd6,
    W_EN_CH    = 4'd7,
    W_GCFG     = 4'd12,
    W_SYNC     = 4'd13
  } word_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
    case (idx)
      3'd0:    return (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h0A;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_en_i,
  input  logic [NUM_CH-1:0] clr_bits_i,
  input  logic [NUM_CH-1:0] set_i,
  output logic [NUM_CH-1:0] flags_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flag_q <= 1'b0;
      else if (set_i[c])                flag_q <= 1'b1;  // set beats clear
      else if (clr_en_i && clr_bits_i[c]) flag_q <= 1'b0;
    end
    assign flags_o[c] = flag_q;
  end
endmodule

// File: rtl/dma_irq_glob.sv
module dma_irq_glob #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          sync_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o,
  output logic [DW-1:0] sync_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      sync_o <= '0;
    end else begin
      if (cfg_we_i)  cfg_o  <= wdata_i;
      if (sync_we_i) sync_o <= wdata_i;
    end
  end
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              main_sel_i,
  input  logic              id_sel_i,
  input  logic [3:0]        word_i,
  input  logic [2:0]        id_idx_i,
  input  logic [NUM_CH-1:0] tc_raw_i,
  input  logic [NUM_CH-1:0] err_raw_i,
  input  logic [NUM_CH-1:0] tc_ie_i,
  input  logic [NUM_CH-1:0] err_ie_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [DW-1:0]     cfg_i,
  input  logic [DW-1:0]     sync_i,
  output logic [DW-1:0]     rdata_o
);
  logic [NUM_CH-1:0] tc_m, err_m;
  assign tc_m  = tc_raw_i & tc_ie_i;
  assign err_m = err_raw_i & err_ie_i;

  always_comb begin
    rdata_o = '0;
    if (id_sel_i) begin
      rdata_o[7:0] = id_byte(id_idx_i, NUM_CH);
    end else if (main_sel_i) begin
      case (word_i)
        W_STAT:     rdata_o = DW'(tc_m | err_m);
        W_TC_STAT:  rdata_o = DW'(tc_m);
        W_ERR_STAT: rdata_o = DW'(err_m);
        W_TC_RAW:   rdata_o = DW'(tc_raw_i);
        W_ERR_RAW:  rdata_o = DW'(err_raw_i);
        W_EN_CH:    rdata_o = DW'(ch_en_i);
        W_GCFG:     rdata_o = cfg_i;
        W_SYNC:     rdata_o = sync_i;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] tc_set_i,
  input  logic [NUM_CH-1:0] err_set_i,
  input  logic [NUM_CH-1:0] tc_ie_i,
  input  logic [NUM_CH-1:0] err_ie_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  output logic              ctrl_en_o,
  output logic              irq_o
);
  logic main_sel, id_sel, wr, rd;
  logic [3:0] word;
  logic [NUM_CH-1:0] tc_raw_q, err_raw_q;
  logic [DW-1:0] cfg_q, sync_q, rd_mux;

  assign main_sel = (addr_i[AW-1:6] == '0);
  assign id_sel   = (addr_i[AW-1:5] == '1);
  assign word     = addr_i[5:2];
  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;

  dma_irq_flags #(.NUM_CH(NUM_CH)) u_tc (
    .clk_i, .rst_ni,
    .clr_en_i  (wr && main_sel && word == W_TC_CLR),
    .clr_bits_i(wdata_i[NUM_CH-1:0]),
    .set_i     (tc_set_i),
    .flags_o   (tc_raw_q)
  );

  dma_irq_flags #(.NUM_CH(NUM_CH)) u_err (
    .clk_i, .rst_ni,
    .clr_en_i  (wr && main_sel && word == W_ERR_CLR),
    .clr_bits_i(wdata_i[NUM_CH-1:0]),
    .set_i     (err_set_i),
    .flags_o   (err_raw_q)
  );

  dma_irq_glob #(.DW(DW)) u_glob (
    .clk_i, .rst_ni,
    .cfg_we_i (wr && main_sel && word == W_GCFG),
    .sync_we_i(wr && main_sel && word == W_SYNC),
    .wdata_i,
    .cfg_o    (cfg_q),
    .sync_o   (sync_q)
  );

  dma_irq_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
    .main_sel_i(main_sel),
    .id_sel_i  (id_sel),
    .word_i    (word),
    .id_idx_i  (addr_i[4:2]),
    .tc_raw_i  (tc_raw_q),
    .err_raw_i (err_raw_q),
    .tc_ie_i,
    .err_ie_i,
    .ch_en_i,
    .cfg_i     (cfg_q),
    .sync_i    (sync_q),
    .rdata_o   (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  assign ctrl_en_o = cfg_q[0];
  assign irq_o     = |((tc_raw_q & tc_ie_i) | (err_raw_q & err_ie_i));
endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [11:0]       addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] tc_set_i,
  input logic [NUM_CH-1:0] err_set_i,
  input logic [NUM_CH-1:0] tc_ie_i,
  input logic [NUM_CH-1:0] err_ie_i,
  input logic              ctrl_en_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] tc_raw,
  input logic [NUM_CH-1:0] err_raw
);
  assert_tc_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_set_i != '0) |=> ((tc_raw & $past(tc_set_i)) == $past(tc_set_i)));

  assert_err_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i != '0 && req_i && we_i && addr_i[11:2] == 10'd4)
      |=> ((err_raw & $past(err_set_i)) == $past(err_set_i)));

  assert_tc_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[11:2] == 10'd2 && tc_set_i == '0)
      |=> ((tc_raw & $past(wdata_i[NUM_CH-1:0])) == '0));

  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((tc_raw | err_raw) != '0));

  assert_irq_after_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|($past(tc_set_i) & tc_ie_i)) && $stable(tc_ie_i)) |-> irq_o);

  assert_soft_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[11:4] == 8'h02) |=> (rdata_o == '0));

  assert_cfg_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[11:2] == 10'd12) |=> (ctrl_en_o == $past(wdata_i[0])));
endmodule

bind dma_irq_regs dma_irq_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .tc_set_i (tc_set_i),
  .err_set_i(err_set_i),
  .tc_ie_i  (tc_ie_i),
  .err_ie_i (err_ie_i),
  .ctrl_en_o(ctrl_en_o),
  .irq_o    (irq_o),
  .tc_raw   (tc_raw_q),
  .err_raw  (err_raw_q)
);

// File: tb/tb_dma_irq_regs.sv
module tb_dma_irq_regs;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] tc_set = '0, err_set = '0, tc_ie = '0, err_ie = '0, ch_en = '0;
  logic ctrl_en, irq;

  int checks = 0, errors = 0;

  // reference model state
  logic [N-1:0] m_tc = '0, m_err = '0;
  logic [31:0]  m_cfg = '0, m_sync = '0;
  logic [7:0]   id_ref [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #5 clk = ~clk;

  dma_irq_regs #(.NUM_CH(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tc_set_i(tc_set), .err_set_i(err_set),
    .tc_ie_i(tc_ie), .err_ie_i(err_ie), .ch_en_i(ch_en),
    .ctrl_en_o(ctrl_en), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [11:0] a);
    logic [N-1:0] tm, em;
    tm = m_tc & tc_ie;
    em = m_err & err_ie;
    if (a >= 12'hFE0) return {24'h0, id_ref[(a - 12'hFE0) >> 2]};
    if (a >= 12'h040) return 32'h0;
    case (a[5:2])
      4'd0:  return 32'(tm | em);
      4'd1:  return 32'(tm);
      4'd3:  return 32'(em);
      4'd5:  return 32'(m_tc);
      4'd6:  return 32'(m_err);
      4'd7:  return 32'(ch_en);
      4'd12: return m_cfg;
      4'd13: return m_sync;
      default: return 32'h0;
    endcase
  endfunction

  // one bus cycle; inputs driven 1 time unit after an edge
  task automatic cyc(input logic r, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic [N-1:0] ts,
                     input logic [N-1:0] es, input string tag);
    logic [31:0] exp_rd;
    req = r; we = w; addr = a; wdata = d; tc_set = ts; err_set = es;
    @(posedge clk);
    exp_rd = model_rd(a);
    if (r && w && a < 12'h040) begin
      case (a[5:2])
        4'd2:  m_tc  = m_tc  & ~d[N-1:0];
        4'd4:  m_err = m_err & ~d[N-1:0];
        4'd12: m_cfg = d;
        4'd13: m_sync = d;
        default: ;
      endcase
    end
    m_tc  = m_tc  | ts;
    m_err = m_err | es;
    #1;
    req = 1'b0; we = 1'b0; tc_set = '0; err_set = '0;
    check({tag, " R9 irq"}, 32'(irq), 32'(|((m_tc & tc_ie) | (m_err & err_ie))));
    check({tag, " R7 ctrl_en"}, 32'(ctrl_en), 32'(m_cfg[0]));
    if (r && !w) check({tag, " rdata"}, rdata, exp_rd);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b1, 1'b0, a, '0, '0, '0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, '0, '0, tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset rdata", rdata, 32'h0);
    check("R9 reset irq", 32'(irq), 32'h0);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    rd(12'h000, "R11 status after reset");
    // R5: set ignores masks
    cyc(1'b0, 1'b0, 12'h000, '0, 8'h09, '0, "R5 tc set");
    rd(12'h014, "R5 raw tc");
    rd(12'h004, "R2 masked tc none");
    tc_ie = 8'h01;
    rd(12'h004, "R2 masked tc ch0");
    rd(12'h000, "R1 status tc");
    cyc(1'b0, 1'b0, 12'h000, '0, '0, 8'h44, "R5 err set");
    err_ie = 8'h04;
    rd(12'h018, "R2 raw err");
    rd(12'h00C, "R2 masked err");
    rd(12'h000, "R1 status combined");
    // R3: write-one-to-clear
    wr(12'h008, 32'h0000_0001, "R3 clear tc ch0");
    rd(12'h014, "R3 raw tc after clear");
    wr(12'h010, 32'hFFFF_FFFF, "R3 clear all err");
    rd(12'h018, "R3 raw err after clear");
    tc_ie = 8'hFF;
    rd(12'h000, "R1 status all enabled");
    // R4: set wins over clear
    cyc(1'b1, 1'b1, 12'h008, 32'h0000_0018, 8'h10, '0, "R4 collide tc");
    rd(12'h014, "R4 raw tc after collide");
    cyc(1'b1, 1'b1, 12'h010, 32'h0000_0080, '0, 8'h80, "R4 collide err");
    rd(12'h018, "R4 raw err after collide");
    // R6
    ch_en = 8'hA5;
    rd(12'h01C, "R6 enabled channels");
    ch_en = 8'h3C;
    rd(12'h01C, "R6 enabled channels 2");
    // R7
    wr(12'h030, 32'h0000_0007, "R7 cfg write");
    rd(12'h030, "R7 cfg read");
    wr(12'h034, 32'hDEAD_BEEF, "R7 sync write");
    rd(12'h034, "R7 sync read");
    wr(12'h030, 32'h1234_5670, "R7 cfg disable");
    rd(12'h030, "R7 cfg read 2");
    // R10: soft request and unmapped
    for (int i = 0; i < 4; i++) wr(12'h020 + 12'(i * 4), 32'hFFFF_FFFF, "R10 soft write");
    for (int i = 0; i < 4; i++) rd(12'h020 + 12'(i * 4), "R10 soft read");
    wr(12'h038, 32'hFFFF_FFFF, "R10 unmapped write");
    wr(12'h148, 32'hFFFF_FFFF, "R10 unmapped high write");
    wr(12'h808, 32'hFFFF_FFFF, "R10 alias write");
    rd(12'h038, "R10 unmapped read");
    rd(12'h148, "R10 unmapped high read");
    rd(12'h014, "R10 tc unchanged");
    rd(12'h018, "R10 err unchanged");
    rd(12'h030, "R10 cfg unchanged");
    rd(12'h034, "R10 sync unchanged");
    // R8
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(i * 4), "R8 id byte");
    // R11: hold on idle and on write
    cyc(1'b0, 1'b0, 12'h030, '0, '0, '0, "R11 idle");
    check("R11 rdata held", rdata, 32'h0000_00B1);
    // R9: mask toggling
    tc_ie = '0; err_ie = '0;
    @(negedge clk);
    check("R9 irq masked off", 32'(irq), 32'h0);
    err_ie = 8'h80;
    @(negedge clk);
    check("R9 irq err on", 32'(irq), 32'h1);
    wr(12'h010, 32'h0000_0080, "R9 clear last err");
    wr(12'h008, 32'h0000_00FF, "R3 clear all tc");
    rd(12'h000, "R1 status empty");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule